// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Controller

This block holds the registered address and burst sequencing for a pipelined synchronous SRAM with an 18-bit word made of two 9-bit lanes. Every control input, the address and the write data are sampled on the rising clock edge. Either of two address-load strobes can start an access. A processor-side strobe always starts a read, and only while the first select is asserted. A controller-side strobe starts a read or a write, depending on the write controls in the same cycle. Either strobe deselects the part when the three selects do not all agree.

Once an access has started, a burst-step input walks the two low address bits through four beats while the upper bits hold. A static order input picks between a wrapping count and an XOR-interleaved order. With no strobe and the step input high, the cycle is a wait: the address holds and the access at that address repeats. Writes land in the same cycle that their address is loaded or stepped. Read data leaves the internal array one clock after its address is registered. An asynchronous output-enable gates the read-data drivers.

The data path is not a stream. There is no valid/ready pair, no back-pressure, and the caller owns the pacing. The internal address is brought out so that burst sequencing can be observed.

Top module: `sbram_addr_ctrl`

## Requirements
- R1: After reset, `mem_addr` is 0, the part is deselected and `rdata` is 0.
- R2: The part is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A controller strobe under any other select state deselects the part. A deselect cycle writes nothing, and it leaves `mem_addr` unchanged. While the part is deselected, steps are ignored and `rdata` reads 0.
- R3: `load_p_n`=0 with `sel_a_n`=0 (and the part selected) loads `addr_in` into `mem_addr` on that edge and starts a read. The read data appears on `rdata` after the following edge, not sooner.
- R4: `load_p_n` has no effect while `sel_a_n`=1.
- R5: A controller strobe (`load_c_n`=0) while the part is selected loads `addr_in`. The cycle is a write if `wr_all_n`=0, or if `lane_gate_n`=0 with some `lane_sel_n` bit at 0. Otherwise it is a read whose data appears one edge later.
- R6: When both strobes are low in the same cycle, the processor strobe wins and the cycle is a read with no write.
- R7: With `seq_interleave`=0, the steps from start low bits s give s+1, s+2 and s+3, modulo 4. Address bits above bit 1 never change.
- R8: With `seq_interleave`=1, the steps from start low bits s give s^1, s^2 and s^3.
- R9: With no strobe and `burst_next_n`=1, `mem_addr` holds.
- R10: The fourth step returns the low bits to s and does not carry into the upper bits.
- R11: `wr_all_n`=0 writes all 18 bits, regardless of `lane_gate_n` and `lane_sel_n`.
- R12: When `wr_all_n`=1, lane k (bits 9k+8:9k, with k=0 as the low lane) is written only if `lane_gate_n`=0 and `lane_sel_n[k]`=0. The other lane keeps its contents.
- R13: `out_en_n`=1 forces `rdata` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the pending read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| sel_a_n | input | 1 | First select (active low), also gates the processor strobe |
| sel_b_n | input | 1 | Second select (active low) |
| sel_c | input | 1 | Third select (active high) |
| load_p_n | input | 1 | Processor address-load strobe, read only |
| load_c_n | input | 1 | Controller address-load strobe |
| burst_next_n | input | 1 | Low steps the burst, high waits |
| wr_all_n | input | 1 | Low writes the whole word |
| lane_gate_n | input | 1 | Low enables the per-lane write selects |
| lane_sel_n | input | LANES | Per-lane write select (active low) |
| seq_interleave | input | 1 | Static burst order: 0 wrap, 1 XOR |
| addr_in | input | ADDR_W | External address |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous read-driver enable (active low) |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| mem_addr | output | ADDR_W | Registered internal address |

## Verification
The bench builds the block with ADDR_W=6, two 9-bit lanes and a 2-bit beat field. The 64-word array keeps the behavioural memory small, and it still leaves four upper address bits free. Each of the eight order/start combinations therefore uses a distinct upper value, so any carry out of the beat bits shows up directly. The two narrow lanes make a partial write easy to tell apart from a full write on read-back.

// File: rtl/sbram_pkg.sv
package sbram_pkg;
  typedef enum logic [2:0] {
    CK_IDLE  = 3'd0,
    CK_LOAD  = 3'd1,
    CK_STEP  = 3'd2,
    CK_HOLD  = 3'd3,
    CK_DESEL = 3'd4
  } cyc_kind_e;
endpackage

// File: rtl/sbram_cycle_ctl.sv
module sbram_cycle_ctl
  import sbram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             load_p_n,
  input  logic             load_c_n,
  input  logic             burst_next_n,
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             active,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lane_we,
  output logic             rd_req
);
  logic             sel_ok;
  logic             p_go;
  logic             c_go;
  logic [LANES-1:0] lanes_req;
  logic             wr_any;

  assign sel_ok = ~sel_a_n & ~sel_b_n & sel_c;
  assign p_go   = ~load_p_n & ~sel_a_n;
  assign c_go   = ~load_c_n;

  always_comb begin
    if (!wr_all_n)        lanes_req = '1;
    else if (!lane_gate_n) lanes_req = ~lane_sel_n;
    else                  lanes_req = '0;
  end
  assign wr_any = |lanes_req;

  always_comb begin
    kind    = CK_IDLE;
    lane_we = '0;
    rd_req  = 1'b0;
    if (p_go) begin
      kind   = sel_ok ? CK_LOAD : CK_DESEL;
      rd_req = sel_ok;
    end else if (c_go) begin
      kind    = sel_ok ? CK_LOAD : CK_DESEL;
      lane_we = sel_ok ? lanes_req : '0;
      rd_req  = sel_ok & ~wr_any;
    end else if (active) begin
      kind    = burst_next_n ? CK_HOLD : CK_STEP;
      lane_we = lanes_req;
      rd_req  = ~wr_any;
    end
  end

  AST_PROC_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_p_n && !sel_a_n) |-> (lane_we == '0)); // R6
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && load_c_n && !active) |-> (kind == CK_IDLE)); // R4
endmodule

// File: rtl/sbram_burst_ctr.sv
module sbram_burst_ctr
  import sbram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_kind_e         kind,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              active
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nx;
  logic [BEAT_W-1:0] low_nx;
  logic [HI_W-1:0]   hi_q;

  assign hi_q    = addr_q[ADDR_W-1:BEAT_W];
  assign beat_nx = beat_q + BEAT_W'(1);
  assign low_nx  = interleave ? (start_q ^ beat_nx) : (start_q + beat_nx);

  always_comb begin
    case (kind)
      CK_LOAD: acc_addr = load_addr;
      CK_STEP: acc_addr = {hi_q, low_nx};
      default: acc_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      active  <= 1'b0;
    end else begin
      case (kind)
        CK_LOAD: begin
          addr_q  <= load_addr;
          start_q <= load_addr[BEAT_W-1:0];
          beat_q  <= '0;
          active  <= 1'b1;
        end
        CK_STEP: begin
          addr_q <= acc_addr;
          beat_q <= beat_nx;
        end
        CK_DESEL: active <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_LOAD) |=> (addr_q == $past(load_addr))); // R3
  AST_STEP_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_STEP) |=> (hi_q == $past(hi_q))); // R7
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_HOLD) |=> $stable(addr_q)); // R9
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_STEP && beat_q == '1) |=> (addr_q[BEAT_W-1:0] == start_q)); // R10
endmodule

// File: rtl/sbram_array.sv
module sbram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_vld    <= 1'b0;
    end else begin
      rd_pend_q <= rd_req;
      rd_vld    <= rd_pend_q;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q <= '0;
      else if (rd_pend_q) lane_q <= cells[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_q;
  end

  AST_READ_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ##1 rd_vld); // R3
endmodule

// File: rtl/sbram_addr_ctrl.sv
module sbram_addr_ctrl
  import sbram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    load_p_n,
  input  logic                    load_c_n,
  input  logic                    burst_next_n,
  input  logic                    wr_all_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    seq_interleave,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [ADDR_W-1:0]       mem_addr
);
  localparam int DATA_W = LANES * LANE_W;

  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_we;
  logic              rd_req;
  logic              active;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld;

  sbram_cycle_ctl #(.LANES(LANES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_a_n      (sel_a_n),
    .sel_b_n      (sel_b_n),
    .sel_c        (sel_c),
    .load_p_n     (load_p_n),
    .load_c_n     (load_c_n),
    .burst_next_n (burst_next_n),
    .wr_all_n     (wr_all_n),
    .lane_gate_n  (lane_gate_n),
    .lane_sel_n   (lane_sel_n),
    .active       (active),
    .kind         (kind),
    .lane_we      (lane_we),
    .rd_req       (rd_req)
  );

  sbram_burst_ctr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .load_addr  (addr_in),
    .interleave (seq_interleave),
    .acc_addr   (acc_addr),
    .addr_q     (mem_addr),
    .active     (active)
  );

  sbram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_addr (acc_addr),
    .lane_we (lane_we),
    .wdata   (wdata),
    .rd_req  (rd_req),
    .rd_addr (mem_addr),
    .rd_data (rd_q),
    .rd_vld  (rd_vld)
  );

  assign rdata = (rd_vld && !out_en_n) ? rd_q : '0;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && load_p_n && load_c_n) |-> (lane_we == '0)); // R2
  AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && !load_c_n && load_p_n && !sel_a_n && !sel_b_n && sel_c)
      |-> (&lane_we)); // R11
endmodule

// File: tb/sbram_addr_ctrl_tb.sv
`timescale 1ns/1ps
module sbram_addr_ctrl_tb;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_a_n, sel_b_n, sel_c, load_p_n, load_c_n, burst_next_n;
  logic wr_all_n, lane_gate_n, seq_interleave, out_en_n;
  logic [1:0]    lane_sel_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sbram_addr_ctrl #(.ADDR_W(AW), .LANES(2), .LANE_W(9), .BEAT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .load_p_n(load_p_n), .load_c_n(load_c_n), .burst_next_n(burst_next_n),
    .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_sel_n(lane_sel_n),
    .seq_interleave(seq_interleave), .addr_in(addr_in), .wdata(wdata),
    .out_en_n(out_en_n), .rdata(rdata), .mem_addr(mem_addr)
  );

  // {order, start, step1, step2, step3}
  localparam logic [8:0] TBL [8] = '{
    9'b0_00_01_10_11, 9'b0_01_10_11_00, 9'b0_10_11_00_01, 9'b0_11_00_01_10,
    9'b1_00_01_10_11, 9'b1_01_00_11_10, 9'b1_10_11_00_01, 9'b1_11_10_01_00
  };

  task automatic idle();
    sel_a_n = 0; sel_b_n = 0; sel_c = 1;
    load_p_n = 1; load_c_n = 1; burst_next_n = 1;
    wr_all_n = 1; lane_gate_n = 1; lane_sel_n = 2'b11; out_en_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] word;
    idle();
    seq_interleave = 0; addr_in = '0; wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 addr after reset", 32'(mem_addr), 0);
    chk("R1 rdata after reset", 32'(rdata), 0);

    // full-word write then processor read
    addr_in = 6'd5; wdata = 18'h2A5A5; load_c_n = 0; wr_all_n = 0;
    tick(); idle();
    load_p_n = 0; addr_in = 6'd5;
    tick(); idle();
    chk("R3 addr loaded", 32'(mem_addr), 5);
    chk("R3 no data before latency", 32'(rdata), 0);
    tick();
    chk("R11 full word read back", 32'(rdata), 32'h2A5A5);

    // low-lane write
    word = {9'(18'h2A5A5 >> 9), 9'h1FF};
    load_c_n = 0; addr_in = 6'd5; wdata = 18'h3FFFF; lane_gate_n = 0; lane_sel_n = 2'b10;
    tick(); idle();
    tick(); tick();
    chk("R12 low lane only", 32'(rdata), 32'(word));

    // lane selects without gate: controller read
    load_c_n = 0; addr_in = 6'd5; wdata = '0; lane_sel_n = 2'b00;
    tick(); idle();
    tick();
    chk("R5 controller read, R12 gate off", 32'(rdata), 32'(word));

    // both strobes with write request: processor wins
    load_p_n = 0; load_c_n = 0; wr_all_n = 0; addr_in = 6'd5; wdata = '0;
    tick(); idle();
    tick();
    chk("R6 processor strobe priority", 32'(rdata), 32'(word));

    // processor strobe gated off by first select
    load_p_n = 0; sel_a_n = 1; addr_in = 6'd9;
    tick(); idle();
    chk("R4 strobe ignored", 32'(mem_addr), 5);

    // asynchronous output enable
    out_en_n = 1; #0.5;
    chk("R13 drivers off", 32'(rdata), 0);
    out_en_n = 0; #0.5;
    chk("R13 drivers on", 32'(rdata), 32'(word));

    // deselecting controller write
    sel_c = 0; load_c_n = 0; wr_all_n = 0; addr_in = 6'd5; wdata = '0;
    tick(); idle(); burst_next_n = 0;
    tick(); tick();
    chk("R2 rdata while deselected", 32'(rdata), 0);
    chk("R2 addr kept", 32'(mem_addr), 5);
    idle(); load_p_n = 0; addr_in = 6'd5;
    tick(); idle(); tick();
    chk("R2 write suppressed", 32'(rdata), 32'(word));

    // burst order table
    for (int i = 0; i < 8; i++) begin
      logic [8:0] e;
      logic [AW-1:0] base;
      string t;
      e = TBL[i];
      t = e[8] ? "R8" : "R7";
      base = {4'(i), e[7:6]};
      seq_interleave = e[8];
      load_p_n = 0; addr_in = base;
      tick(); idle();
      chk({t, " start"}, 32'(mem_addr), 32'(base));
      burst_next_n = 0; tick();
      chk({t, " step1"}, 32'(mem_addr), 32'({4'(i), e[5:4]}));
      burst_next_n = 1; tick();
      chk("R9 wait holds", 32'(mem_addr), 32'({4'(i), e[5:4]}));
      burst_next_n = 0; tick();
      chk({t, " step2"}, 32'(mem_addr), 32'({4'(i), e[3:2]}));
      tick();
      chk({t, " step3"}, 32'(mem_addr), 32'({4'(i), e[1:0]}));
      tick();
      chk("R10 wrap to start", 32'(mem_addr), 32'(base));
      idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule